// File: doc/BRIEF.md
# Dual-Line Edge Interrupt Controller

This block is a second-stage interrupt controller for up to 24 level inputs. Each input passes through a two-flop synchronizer and an edge detector. A per-source 2-bit trigger code selects rising edges, falling edges, both, or neither. A detected edge is latched into a status register. There are two independent host lines, and each has its own status register, its own mask register and its own active-low interrupt output. One trigger-select register serves both lines.

A byte-wide register port gives access to all registers. A control register chooses one of two ways to acknowledge status: a status read clears the bits it returns, or the host writes ones to the bits it wants cleared. The same register can make the controller hold a second edge that arrives while a status bit is still set. It can also route each event to only one of the two lines.

Top module: `dual_line_irq`

Register map (5-bit address):

| Address | Contents |
|---|---|
| 0x00 | line 0 status |
| 0x04 | line 0 mask |
| 0x08 | line 1 status |
| 0x0C | line 1 mask |
| 0x10 | trigger select |
| 0x18 | control |

Multi-byte registers occupy consecutive addresses from their base, lowest byte first.

## Requirements
- R1: After reset all status bits are 0, every implemented mask bit is 1, every trigger code is 00, the control register is 0 and both `irq_n` outputs are high.
- R2: Source i owns bits [2*(i%4)+1 : 2*(i%4)] of trigger byte i/4 (address 0x10 + i/4). The upper bit enables rising-edge capture and the lower bit enables falling-edge capture. Code 00 never sets a status bit.
- R3: When a source input changes just before a rising clock edge, its status bit is set at the third rising edge at which the new level is present.
- R4: With control bit 0 (exclusive) at 0, an enabled edge sets the source's status bit on both lines.
- R5: `irq_n[l]` is low exactly when line l has a status bit set whose mask bit is 0. A mask bit of 1 removes that source from the line's output but leaves its status intact.
- R6: With control bit 2 (clear-on-read) at 1, a status byte read returns the current bits and clears them. Writes to status bytes have no effect in this mode.
- R7: With control bit 2 at 0, reads leave status unchanged. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: With control bit 1 (pending-disable) at 0, a second edge that arrives while the bit is set is held. The first clear then leaves the bit set and the second clear removes it. With control bit 1 at 1, one clear always empties the bit.
- R9: When an edge and a clear reach the same status bit in the same cycle, the bit ends up set.
- R10: With control bit 0 at 1, an event goes only to line 0 if the source is unmasked on line 0, and otherwise goes only to line 1.
- R11: Status and mask registers are ceil(N/8) bytes and the trigger register is ceil(2N/8) bytes. Implemented bits above N-1 and unmapped addresses read as 0. Only the three control bits are stored. Read data appears on `reg_rdata` in the cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Asynchronous interrupt source levels |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_rd | input | 1 | Read strobe for `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq_n | output | 2 | Active-low interrupt, one per host line |

## Verification
The case that needs the most care is an edge that reaches the latch in the same cycle as a clear of the same bit. The bench provokes this with a read strobe in clear-on-read mode. It sets a status bit first. It then drops the source and counts two clock edges after the change, so that the read strobe lands on the exact edge where the falling-edge event latches. The bench judges the result from the next two reads: the first must still return the bit, and the second must return zero. A lost event would show up as zero on the first of these reads.

// File: rtl/dlirq_pkg.sv
package dlirq_pkg;

  localparam logic [4:0] A_STAT0 = 5'h00;
  localparam logic [4:0] A_MASK0 = 5'h04;
  localparam logic [4:0] A_STAT1 = 5'h08;
  localparam logic [4:0] A_MASK1 = 5'h0C;
  localparam logic [4:0] A_EDGE  = 5'h10;
  localparam logic [4:0] A_CTRL  = 5'h18;

  // control byte: bit2 clear-on-read, bit1 pending-disable, bit0 exclusive
  typedef struct packed {
    logic cor;
    logic pdis;
    logic excl;
  } ctrl_t;

  function automatic int bytes_for(int nbits);
    return (nbits + 7) / 8;
  endfunction

  function automatic logic addr_is(logic [4:0] a, logic [4:0] base, int idx);
    return a == (base + 5'(idx));
  endfunction

  function automatic logic [4:0] stat_base(int line);
    return (line == 0) ? A_STAT0 : A_STAT1;
  endfunction

  function automatic logic [4:0] mask_base(int line);
    return (line == 0) ? A_MASK0 : A_MASK1;
  endfunction

  // code[1] = rising capture, code[0] = falling capture
  function automatic logic edge_hit(logic [1:0] code, logic rise, logic fall);
    return (code[1] & rise) | (code[0] & fall);
  endfunction

endpackage

// File: rtl/dl_edge_sync.sv
module dl_edge_sync import dlirq_pkg::*; #(
  parameter int N = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] trig_i,
  output logic [N-1:0]   ev_o
);

  logic [N-1:0] s1_q, s2_q, s3_q;
  logic [N-1:0] rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_w = s2_q & ~s3_q;
  assign fall_w = ~s2_q & s3_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign ev_o[g] = edge_hit(trig_i[2*g+1 -: 2], rise_w[g], fall_w[g]);
  end

endmodule

// File: rtl/dl_line_latch.sv
module dl_line_latch #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic         pend_dis_i,
  output logic [N-1:0] stat_o
);

  logic [N-1:0] stat_q, pend_q, stat_d, pend_d;

  // a new event always lands; a clear promotes the held event
  assign stat_d = ev_i | (~clr_i & stat_q) | (clr_i & pend_q);
  assign pend_d = (~clr_i & (pend_q | (ev_i & stat_q & {N{~pend_dis_i}})))
                | (clr_i & ev_i & pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  assign stat_o = stat_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((stat_q & $past(ev_i)) == $past(ev_i)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(ev_i)) == '0));

  // R8
  pend_under_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~stat_q) == '0));

  // R8
  pend_dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_dis_i |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/dual_line_irq.sv
module dual_line_irq import dlirq_pkg::*; #(
  parameter int N_SRC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [4:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [1:0]       irq_n
);

  localparam int EW = 2 * N_SRC;

  initial begin
    if (N_SRC < 1 || N_SRC > 24 || bytes_for(EW) > 6) $error("N_SRC out of range");
  end

  logic [N_SRC-1:0] stat    [2];
  logic [N_SRC-1:0] mask_q  [2];
  logic [N_SRC-1:0] clr_w   [2];
  logic [N_SRC-1:0] ev_line [2];
  logic [EW-1:0]    trig_q;
  logic [N_SRC-1:0] ev_w;
  ctrl_t            ctrl_q;
  logic [7:0]       rd_mux;

  // register writes: masks, trigger select, control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q[0] <= '1;
      mask_q[1] <= '1;
      trig_q    <= '0;
      ctrl_q    <= '0;
    end else if (reg_wr) begin
      for (int l = 0; l < 2; l++)
        for (int i = 0; i < N_SRC; i++)
          if (addr_is(reg_addr, mask_base(l), i / 8)) mask_q[l][i] <= reg_wdata[i % 8];
      for (int i = 0; i < EW; i++)
        if (addr_is(reg_addr, A_EDGE, i / 8)) trig_q[i] <= reg_wdata[i % 8];
      if (reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[2:0]);
    end
  end

  dl_edge_sync #(.N(N_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .trig_i (trig_q),
    .ev_o   (ev_w)
  );

  // line routing and clear requests
  always_comb begin
    ev_line[0] = ctrl_q.excl ? (ev_w & ~mask_q[0]) : ev_w;
    ev_line[1] = ctrl_q.excl ? (ev_w & mask_q[0])  : ev_w;
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < N_SRC; i++)
        clr_w[l][i] = ctrl_q.cor
          ? (reg_rd && addr_is(reg_addr, stat_base(l), i / 8))
          : (reg_wr && addr_is(reg_addr, stat_base(l), i / 8) && reg_wdata[i % 8]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_line
    dl_line_latch #(.N(N_SRC)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev_line[g]),
      .clr_i      (clr_w[g]),
      .pend_dis_i (ctrl_q.pdis),
      .stat_o     (stat[g])
    );
    assign irq_n[g] = ~|(stat[g] & ~mask_q[g]);
  end

  // read mux and registered read data
  always_comb begin
    rd_mux = '0;
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < N_SRC; i++) begin
        if (addr_is(reg_addr, stat_base(l), i / 8)) rd_mux[i % 8] = stat[l][i];
        if (addr_is(reg_addr, mask_base(l), i / 8)) rd_mux[i % 8] = mask_q[l][i];
      end
    for (int i = 0; i < EW; i++)
      if (addr_is(reg_addr, A_EDGE, i / 8)) rd_mux[i % 8] = trig_q[i];
    if (reg_addr == A_CTRL) rd_mux = {5'b0, ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: tb/sim_dual_line_irq.sv
module sim_dual_line_irq;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [4:0]   addr = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [1:0]   irq_n;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_line_irq #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_n));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rd_stat16(int line, output int v);
    logic [7:0] b0, b1;
    logic [4:0] base;
    base = (line == 0) ? 5'h00 : 5'h08;
    rd_reg(base, b0);
    rd_reg(base + 5'd1, b1);
    v = {16'h0, b1, b0};
  endtask

  task automatic drive_src(int i, logic v);
    @(negedge clk); src[i] = v;
    repeat (4) @(negedge clk);
  endtask

  // trigger bytes that give source i the 2-bit code and all others 00
  task automatic set_trig(int i, logic [1:0] code);
    for (int b = 0; b < 3; b++)
      wr_reg(5'h10 + 5'(b), (b == i / 4) ? 8'(code << (2 * (i % 4))) : 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v0, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_n", irq_n, 2'b11);
    rd_stat16(0, v0); chk("R1 stat0", v0, 0);
    rd_stat16(1, v1); chk("R1 stat1", v1, 0);
    rd_reg(5'h04, d); chk("R1 mask0 b0", d, 8'hFF);
    rd_reg(5'h05, d); chk("R1 mask0 b1", d, 8'h0F);
    rd_reg(5'h0D, d); chk("R1 mask1 b1", d, 8'h0F);
    rd_reg(5'h10, d); chk("R1 trig b0", d, 0);
    rd_reg(5'h12, d); chk("R1 trig b2", d, 0);
    rd_reg(5'h18, d); chk("R1 ctrl", d, 0);

    // R2 R4 R6 sweep over every source and every trigger code
    wr_reg(5'h18, 8'h04);
    for (int i = 0; i < N; i++)
      for (int c = 0; c < 4; c++) begin
        set_trig(i, 2'(c));
        drive_src(i, 1'b1);
        rd_stat16(0, v0); rd_stat16(1, v1);
        chk("R2 rise line0", v0, c[1] ? (1 << i) : 0);
        chk("R4 rise line1", v1, c[1] ? (1 << i) : 0);
        rd_stat16(0, v0); chk("R6 cleared by read", v0, 0);
        drive_src(i, 1'b0);
        rd_stat16(0, v0); rd_stat16(1, v1);
        chk("R2 fall line0", v0, c[0] ? (1 << i) : 0);
        chk("R4 fall line1", v1, c[0] ? (1 << i) : 0);
      end

    // R6 status write ignored in clear-on-read mode
    set_trig(0, 2'b11);
    drive_src(0, 1'b1);
    wr_reg(5'h00, 8'hFF);
    rd_reg(5'h00, d); chk("R6 write ignored", d, 8'h01);
    rd_reg(5'h08, d);
    drive_src(0, 1'b0);
    rd_reg(5'h00, d); rd_reg(5'h08, d);

    // R3 latency, R5 masking
    set_trig(0, 2'b10);
    wr_reg(5'h04, 8'hFE);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); chk("R3 after edge 1", irq_n[0], 1);
    @(negedge clk); chk("R3 after edge 2", irq_n[0], 1);
    @(negedge clk); chk("R3 after edge 3", irq_n[0], 0);
    chk("R5 line1 masked", irq_n[1], 1);
    wr_reg(5'h04, 8'hFF);
    chk("R5 mask hides line0", irq_n[0], 1);
    wr_reg(5'h0C, 8'hFE);
    chk("R5 unmask line1", irq_n[1], 0);
    rd_reg(5'h00, d); chk("R5 status kept under mask", d, 8'h01);
    rd_reg(5'h08, d);
    chk("R5 irq released", irq_n, 2'b11);
    wr_reg(5'h0C, 8'hFF);
    drive_src(0, 1'b0);

    // R7 write-one-to-clear
    wr_reg(5'h18, 8'h00);
    set_trig(1, 2'b11);
    drive_src(1, 1'b1);
    rd_reg(5'h00, d); chk("R7 read", d, 8'h02);
    rd_reg(5'h00, d); chk("R7 read keeps", d, 8'h02);
    wr_reg(5'h00, 8'hFD);
    rd_reg(5'h00, d); chk("R7 write zero keeps", d, 8'h02);
    wr_reg(5'h00, 8'h02);
    rd_reg(5'h00, d); chk("R7 write one clears", d, 8'h00);
    wr_reg(5'h08, 8'h02);
    drive_src(1, 1'b0);
    wr_reg(5'h00, 8'hFF); wr_reg(5'h08, 8'hFF);
    wr_reg(5'h00, 8'hFF); wr_reg(5'h08, 8'hFF);

    // R8 pending buffer enabled, then disabled
    wr_reg(5'h18, 8'h04);
    drive_src(1, 1'b1); drive_src(1, 1'b0);
    rd_reg(5'h00, d); chk("R8 first clear", d, 8'h02);
    rd_reg(5'h00, d); chk("R8 held event", d, 8'h02);
    rd_reg(5'h00, d); chk("R8 drained", d, 8'h00);
    repeat (3) rd_reg(5'h08, d);
    wr_reg(5'h18, 8'h06);
    drive_src(1, 1'b1); drive_src(1, 1'b0);
    rd_reg(5'h00, d); chk("R8 pdis first", d, 8'h02);
    rd_reg(5'h00, d); chk("R8 pdis single clear", d, 8'h00);
    repeat (2) rd_reg(5'h08, d);

    // R9 event and read-clear on the same edge
    wr_reg(5'h18, 8'h04);
    drive_src(1, 1'b1);
    @(negedge clk); src[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = 5'h00; rd = 1'b1;
    @(negedge clk); rd = 1'b0; chk("R9 read value", rdata, 8'h02);
    rd_reg(5'h00, d); chk("R9 set wins", d, 8'h02);
    rd_reg(5'h00, d); chk("R9 then clear", d, 8'h00);
    repeat (2) rd_reg(5'h08, d);

    // R10 exclusive routing
    wr_reg(5'h18, 8'h05);
    set_trig(2, 2'b11);
    wr_reg(5'h04, 8'h00);
    drive_src(2, 1'b1);
    rd_reg(5'h00, d); chk("R10 line0 gets", d, 8'h04);
    rd_reg(5'h08, d); chk("R10 line1 skipped", d, 8'h00);
    wr_reg(5'h04, 8'hFF);
    drive_src(2, 1'b0);
    rd_reg(5'h00, d); chk("R10 line0 skipped", d, 8'h00);
    rd_reg(5'h08, d); chk("R10 line1 gets", d, 8'h04);

    // R11 widths, unused bits and addresses
    wr_reg(5'h12, 8'hA5);
    rd_reg(5'h12, d); chk("R11 trig b2", d, 8'hA5);
    wr_reg(5'h05, 8'hFF);
    rd_reg(5'h05, d); chk("R11 mask high bits", d, 8'h0F);
    rd_reg(5'h1F, d); chk("R11 unmapped", d, 8'h00);
    wr_reg(5'h18, 8'hFF);
    rd_reg(5'h18, d); chk("R11 ctrl bits", d, 8'h07);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule